// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. A free-running counter, shared with the other channels, comes in as a plain input together with its stop and hold-in-reset controls. A five-bit control word chooses how the channel behaves. It can capture the counter value on an edge of its pin. It can change its output level when the counter reaches a stored value, in unbuffered or buffered form. It can also release its pin to an alternate-function signal while holding a preset output level ready.

Software writes the control word and the channel value through a simple strobe-and-data port. It reads the channel value back and watches a flag and an interrupt request. Clearing the flag takes two steps: a read strobe that sees the flag set, then a clear strobe. In buffered mode a new value is parked in a second register and becomes active only when the counter wraps. This lets a PWM period change without glitching.

Top module: `tcc_channel`

## Requirements
- R1: After a synchronous active-low reset, the edge/level bits, mode bits and enable are zero, so the channel is released. In that state flag_o and irq_o are 0, lvl_o is 1 and pin_oe_o is 1.
- R2: When both edge/level bits (ctl bits [1:0]) are 0, the channel is released whatever the mode bits hold. pin_o follows alt_i and pin_oe_o is 1. One edge after the control register shows it, lvl_o becomes 1 if mode-A (ctl bit [2]) is 0 and 0 if mode-A is 1.
- R3: With mode-B = 0, mode-A = 0 and non-zero edge bits, the channel is an input capture and pin_oe_o is 0. Edge bits 01 select rising edges of pin_i, 10 falling edges and 11 either edge. A qualifying edge of pin_i loads the counter value into the channel value (read on val_rdata_o) and sets flag_o at the third rising clock edge after pin_i changes. Edges that do not qualify change nothing.
- R4: With mode-B = 0, mode-A = 1 and non-zero edge bits, the channel is an unbuffered compare. val_we_i loads the value directly. A clock edge at which cnt_i differs from its value at the previous edge and equals the channel value is a match. At that edge flag_o is set and lvl_o is toggled (edge bits 01), cleared (10) or set (11). pin_o equals lvl_o.
- R5: With mode-B = 1 and non-zero edge bits, the channel is a buffered compare with the same three actions. A value write is held in a second register. val_rdata_o and the match keep using the old value until a clock edge at which the counter advances to its all-ones value. After that edge the new value is active.
- R6: Control word layout: bit 4 interrupt enable, bit 3 mode-B, bit 2 mode-A, bit 1 edge B, bit 0 edge A. A control write always updates the enable. It updates the mode and edge bits only when cnt_stop_i and cnt_rst_i are both 1; otherwise those bits are ignored.
- R7: While cnt_i holds the same value, no further match occurs, even though it equals the channel value.
- R8: flag_clr_i clears the flag only when an earlier flag_rd_i strobe saw flag_o = 1. A clear strobe that was not armed this way leaves flag_o at 1.
- R9: When an armed clear and a new capture or match fall in the same cycle, flag_o is 0 afterwards.
- R10: irq_o is 1 exactly when flag_o is 1 and the interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | CNT_W | Shared free-running counter value |
| cnt_stop_i | input | 1 | Shared counter is stopped |
| cnt_rst_i | input | 1 | Shared counter is held in reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 5 | Control word {enable, mode-B, mode-A, edge B, edge A} |
| val_we_i | input | 1 | Channel value write strobe |
| val_wdata_i | input | CNT_W | Channel value write data |
| val_rdata_o | output | CNT_W | Active channel value (captured or compare) |
| flag_rd_i | input | 1 | Software read of the flag (arms the clear) |
| flag_clr_i | input | 1 | Software write of 0 to the flag |
| flag_o | output | 1 | Channel event flag |
| irq_o | output | 1 | Interrupt request |
| pin_i | input | 1 | Channel pin input (asynchronous) |
| alt_i | input | 1 | Alternate-function signal for the released pin |
| pin_o | output | 1 | Value driven onto the channel pin |
| pin_oe_o | output | 1 | Pin output enable |
| lvl_o | output | 1 | Internal channel output level |

## Verification
The hardest case to reach is a clear strobe that is armed and lands on the same edge as a fresh compare match. That takes a flag already set by a match, a read that arms the clear, the counter stepped away from the compare value, and then stepped back in the very cycle the clear is strobed. A directed task walks that sequence. The buffered reload is reached by parking a value and proving that the old value still matches. Only after that does the task step the counter to all ones and observe the swap on the read port.

// File: rtl/tcc_pkg.sv
// Package: shared types for the timer capture/compare channel.
// Assumes: nothing beyond IEEE 1800-2017.
package tcc_pkg;

    // Behaviour selected by the mode and edge/level bits.
    typedef enum logic [1:0] {
        CH_RELEASED = 2'd0,
        CH_CAPTURE  = 2'd1,
        CH_COMPARE  = 2'd2,
        CH_BUFFERED = 2'd3
    } ch_kind_e;

    // Output action applied on a compare match.
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } cmp_act_e;

endpackage

// File: rtl/tcc_decode.sv
// Module: tcc_decode
// Turns the two mode bits and the two edge/level bits into the channel kind,
// the capture edge enables, the compare action and the preset level.
// Assumes: purely combinational; the caller registers the inputs.
module tcc_decode
    import tcc_pkg::*;
(
    input  logic     mode_b_i,
    input  logic     mode_a_i,
    input  logic     edge_b_i,
    input  logic     edge_a_i,
    output ch_kind_e kind_o,
    output logic     rise_en_o,
    output logic     fall_en_o,
    output cmp_act_e act_o,
    output logic     preset_lvl_o
);

    // Decode the four control bits into behaviours.
    always_comb begin
        rise_en_o    = 1'b0;
        fall_en_o    = 1'b0;
        act_o        = ACT_NONE;
        preset_lvl_o = ~mode_a_i;
        if (!edge_b_i && !edge_a_i) begin
            kind_o = CH_RELEASED;
        end else if (mode_b_i) begin
            kind_o = CH_BUFFERED;
            act_o  = cmp_act_e'({edge_b_i, edge_a_i});
        end else if (mode_a_i) begin
            kind_o = CH_COMPARE;
            act_o  = cmp_act_e'({edge_b_i, edge_a_i});
        end else begin
            kind_o    = CH_CAPTURE;
            rise_en_o = edge_a_i;
            fall_en_o = edge_b_i;
        end
    end

endmodule

// File: rtl/tcc_edge_sync.sv
// Module: tcc_edge_sync
// Brings the asynchronous pin into the clock domain through a chain of
// STAGES flops, then flags rising and falling edges of the synchronized copy.
// Assumes: STAGES >= 2; pin held stable two clocks before capture is enabled.
module tcc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES:0] chain;
    logic            last_q;

    assign chain[0] = pin_i;

    // One synchronizer flop per stage.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s+1] <= 1'b0;
            else        chain[s+1] <= chain[s];
        end
    end

    // Remember the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES];
    end

    assign rise_o = chain[STAGES] & ~last_q;
    assign fall_o = ~chain[STAGES] & last_q;

    // R3: a detected edge reflects a change that already passed the chain.
    a_r3_edge_from_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o || fall_o) |=> last_q == $past(chain[STAGES]));

endmodule

// File: rtl/tcc_value_regs.sv
// Module: tcc_value_regs
// Holds the active channel value and, for buffered compare, a pending copy
// that moves into the active register on the counter-wrap reload strobe.
// Assumes: capture and buffered mode never coincide (decoder guarantees).
module tcc_value_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buffered_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             reload_i,
    input  logic             cap_i,
    input  logic [CNT_W-1:0] cap_val_i,
    output logic [CNT_W-1:0] active_o
);

    logic [CNT_W-1:0] active_q;
    logic [CNT_W-1:0] pend_q;
    logic             pend_vld_q;

    // Park buffered writes and track whether a reload is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else if (wr_i && buffered_i) begin
            pend_q     <= wdata_i;
            pend_vld_q <= 1'b1;
        end else if (reload_i) begin
            pend_vld_q <= 1'b0;
        end
    end

    // Update the active value from capture, direct write or reload.
    always_ff @(posedge clk) begin
        if (!rst_n)                     active_q <= '0;
        else if (cap_i)                 active_q <= cap_val_i;
        else if (wr_i && !buffered_i)   active_q <= wdata_i;
        else if (reload_i && pend_vld_q) active_q <= pend_q;
    end

    assign active_o = active_q;

    // R5: in buffered mode the active value only moves at a reload.
    a_r5_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered_i && !reload_i && !cap_i) |=> $stable(active_q));

endmodule

// File: rtl/tcc_channel.sv
// Module: tcc_channel
// One capture/compare channel of a timer sharing a free-running counter.
// Holds the control word, detects capture edges and compare matches, drives
// the channel output level and pin, and manages the flag and interrupt.
// Assumes: cnt_i is synchronous to clk; pin_i is asynchronous.
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_stop_i,
    input  logic             cnt_rst_i,
    input  logic             ctl_we_i,
    input  logic [4:0]       ctl_wdata_i,
    input  logic             val_we_i,
    input  logic [CNT_W-1:0] val_wdata_i,
    output logic [CNT_W-1:0] val_rdata_o,
    input  logic             flag_rd_i,
    input  logic             flag_clr_i,
    output logic             flag_o,
    output logic             irq_o,
    input  logic             pin_i,
    input  logic             alt_i,
    output logic             pin_o,
    output logic             pin_oe_o,
    output logic             lvl_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic             ie_q, mode_b_q, mode_a_q, edge_b_q, edge_a_q;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q, armed_q, lvl_q;
    ch_kind_e         kind;
    cmp_act_e         act;
    logic             rise_en, fall_en, preset_lvl;
    logic             rise, fall;
    logic [CNT_W-1:0] active;
    logic             halted, adv, is_cmp, match, reload, cap_evt, clr_eff;

    assign halted = cnt_stop_i & cnt_rst_i;

    // Control register; function bits change only while the counter is halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q     <= 1'b0;
            mode_b_q <= 1'b0;
            mode_a_q <= 1'b0;
            edge_b_q <= 1'b0;
            edge_a_q <= 1'b0;
        end else if (ctl_we_i) begin
            ie_q <= ctl_wdata_i[4];
            if (halted) begin
                mode_b_q <= ctl_wdata_i[3];
                mode_a_q <= ctl_wdata_i[2];
                edge_b_q <= ctl_wdata_i[1];
                edge_a_q <= ctl_wdata_i[0];
            end
        end
    end

    tcc_decode u_decode (
        .mode_b_i     (mode_b_q),
        .mode_a_i     (mode_a_q),
        .edge_b_i     (edge_b_q),
        .edge_a_i     (edge_a_q),
        .kind_o       (kind),
        .rise_en_o    (rise_en),
        .fall_en_o    (fall_en),
        .act_o        (act),
        .preset_lvl_o (preset_lvl)
    );

    tcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    // Remember the counter value of the previous edge to detect advances.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_i;
    end

    assign adv     = (cnt_i != cnt_q);
    assign is_cmp  = (kind == CH_COMPARE) || (kind == CH_BUFFERED);
    assign match   = adv && is_cmp && (cnt_i == active);
    assign reload  = adv && (kind == CH_BUFFERED) && (cnt_i == CNT_TOP);
    assign cap_evt = (kind == CH_CAPTURE) && ((rise && rise_en) || (fall && fall_en));
    assign clr_eff = flag_clr_i && armed_q;

    tcc_value_regs #(.CNT_W(CNT_W)) u_vals (
        .clk        (clk),
        .rst_n      (rst_n),
        .buffered_i (kind == CH_BUFFERED),
        .wr_i       (val_we_i),
        .wdata_i    (val_wdata_i),
        .reload_i   (reload),
        .cap_i      (cap_evt),
        .cap_val_i  (cnt_i),
        .active_o   (active)
    );

    // Arm the clear once software has seen the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n)                    armed_q <= 1'b0;
        else if (clr_eff)              armed_q <= 1'b0;
        else if (flag_rd_i && flag_q)  armed_q <= 1'b1;
    end

    // Flag: an armed clear wins over a simultaneous event.
    always_ff @(posedge clk) begin
        if (!rst_n)                   flag_q <= 1'b0;
        else if (clr_eff)             flag_q <= 1'b0;
        else if (match || cap_evt)    flag_q <= 1'b1;
    end

    // Output level: preset while released, compare action on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b1;
        end else if (kind == CH_RELEASED) begin
            lvl_q <= preset_lvl;
        end else if (match) begin
            case (act)
                ACT_TOGGLE: lvl_q <= ~lvl_q;
                ACT_CLEAR:  lvl_q <= 1'b0;
                ACT_SET:    lvl_q <= 1'b1;
                default:    lvl_q <= lvl_q;
            endcase
        end
    end

    assign val_rdata_o = active;
    assign flag_o      = flag_q;
    assign irq_o       = flag_q & ie_q;
    assign lvl_o       = lvl_q;
    assign pin_o       = (kind == CH_RELEASED) ? alt_i : lvl_q;
    assign pin_oe_o    = (kind != CH_CAPTURE);

    // R1: reset leaves the channel released with the flag down.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (kind == CH_RELEASED) && !flag_q);

    // R6: function bits hold when written while the counter runs.
    a_r6_ctl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && !halted) |=> $stable({mode_b_q, mode_a_q, edge_b_q, edge_a_q}));

    // R4: a toggle match inverts the level at that edge.
    a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act == ACT_TOGGLE) |=> lvl_q != $past(lvl_q));

    // R7: with the counter not advancing, a compare level stays put.
    a_r7_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && kind != CH_RELEASED) |=> $stable(lvl_q));

    // R9: an armed clear always leaves the flag low.
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_eff |=> !flag_q);

    // R3: an unopposed capture event raises the flag.
    a_r3_capture_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && !clr_eff) |=> flag_q);

endmodule

// File: tb/tb_tcc_channel.sv
module tb_tcc_channel;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_i = '0;
    logic         cnt_stop_i = 1'b0, cnt_rst_i = 1'b0;
    logic         ctl_we_i = 1'b0;
    logic [4:0]   ctl_wdata_i = '0;
    logic         val_we_i = 1'b0;
    logic [W-1:0] val_wdata_i = '0;
    logic [W-1:0] val_rdata_o;
    logic         flag_rd_i = 1'b0, flag_clr_i = 1'b0;
    logic         flag_o, irq_o;
    logic         pin_i = 1'b0, alt_i = 1'b0;
    logic         pin_o, pin_oe_o, lvl_o;

    int n_chk = 0;
    int n_bad = 0;

    tcc_channel #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i),
        .cnt_stop_i(cnt_stop_i), .cnt_rst_i(cnt_rst_i),
        .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
        .val_we_i(val_we_i), .val_wdata_i(val_wdata_i), .val_rdata_o(val_rdata_o),
        .flag_rd_i(flag_rd_i), .flag_clr_i(flag_clr_i),
        .flag_o(flag_o), .irq_o(irq_o),
        .pin_i(pin_i), .alt_i(alt_i),
        .pin_o(pin_o), .pin_oe_o(pin_oe_o), .lvl_o(lvl_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Control write; halt selects whether stop and reset are both asserted.
    task automatic ctl_w(input logic [4:0] w, input logic halt);
        ctl_wdata_i = w;
        ctl_we_i    = 1'b1;
        cnt_stop_i  = halt;
        cnt_rst_i   = halt;
        tick();
        ctl_we_i    = 1'b0;
        cnt_stop_i  = 1'b0;
        cnt_rst_i   = 1'b0;
    endtask

    task automatic val_w(input logic [W-1:0] v);
        val_wdata_i = v;
        val_we_i    = 1'b1;
        tick();
        val_we_i    = 1'b0;
    endtask

    task automatic clear_flag();
        flag_rd_i = 1'b1; tick(); flag_rd_i = 1'b0;
        flag_clr_i = 1'b1; tick(); flag_clr_i = 1'b0;
    endtask

    task automatic step(input logic [W-1:0] c);
        cnt_i = c;
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick();
        check("R1 flag", flag_o, 0);
        check("R1 irq", irq_o, 0);
        check("R1 lvl", lvl_o, 1);
        check("R1 oe", pin_oe_o, 1);
        alt_i = 1'b1; #1;
        check("R1 pin follows alt", pin_o, 1);
        alt_i = 1'b0;
    endtask

    task automatic t_capture();
        ctl_w(5'b0_0001, 1'b1);               // rising edge capture
        check("R3 oe off in capture", pin_oe_o, 0);
        step(16'h1234);
        pin_i = 1'b1;
        tick(2);
        check("R3 no flag before third edge", flag_o, 0);
        tick();
        check("R3 rise flag", flag_o, 1);
        check("R3 rise value", val_rdata_o, 16'h1234);
        clear_flag();
        step(16'h2222);
        pin_i = 1'b0;
        tick(4);
        check("R3 falling ignored flag", flag_o, 0);
        check("R3 falling ignored value", val_rdata_o, 16'h1234);
        ctl_w(5'b0_0011, 1'b1);               // either edge
        pin_i = 1'b1;
        tick(4);
        check("R3 both rise", val_rdata_o, 16'h2222);
        clear_flag();
        step(16'h3333);
        pin_i = 1'b0;
        tick(4);
        check("R3 both fall flag", flag_o, 1);
        check("R3 both fall value", val_rdata_o, 16'h3333);
        clear_flag();
        ctl_w(5'b0_0010, 1'b1);               // falling only
        pin_i = 1'b1;
        tick(4);
        check("R3 rise ignored in fall mode", flag_o, 0);
        step(16'h4444);
        pin_i = 1'b0;
        tick(4);
        check("R3 fall only value", val_rdata_o, 16'h4444);
        clear_flag();
    endtask

    task automatic t_compare();
        ctl_w(5'b1_0101, 1'b1);               // unbuffered, toggle, enable on
        val_w(16'h0005);
        step(16'h0003);
        step(16'h0004);
        check("R4 no early match", lvl_o, 1);
        step(16'h0005);
        check("R4 toggle level", lvl_o, 0);
        check("R4 flag on match", flag_o, 1);
        check("R10 irq with enable", irq_o, 1);
        check("R4 pin drives level", pin_o, 0);
        tick(3);
        check("R7 held counter no retoggle", lvl_o, 0);
        flag_clr_i = 1'b1; tick(); flag_clr_i = 1'b0;
        check("R8 unarmed clear ignored", flag_o, 1);
        flag_rd_i = 1'b1; tick(); flag_rd_i = 1'b0;
        step(16'h0004);
        cnt_i = 16'h0005;
        flag_clr_i = 1'b1; tick(); flag_clr_i = 1'b0;
        check("R9 clear beats match", flag_o, 0);
        check("R9 match still toggles", lvl_o, 1);
        ctl_w(5'b1_0110, 1'b1);               // clear action
        step(16'h0006);
        step(16'h0005);
        check("R4 clear action", lvl_o, 0);
        ctl_w(5'b1_0111, 1'b1);               // set action
        step(16'h0006);
        step(16'h0005);
        check("R4 set action", lvl_o, 1);
        alt_i = 1'b0;
        ctl_w(5'b0_0000, 1'b0);               // running: only enable changes
        tick();
        check("R10 irq masked", irq_o, 0);
        check("R10 flag still set", flag_o, 1);
        check("R6 function kept oe", pin_oe_o, 1);
        check("R6 function kept pin", pin_o, 1);
        clear_flag();
    endtask

    task automatic t_buffered();
        ctl_w(5'b0_1010, 1'b1);               // buffered, clear action
        val_w(16'h0010);
        check("R5 old value active", val_rdata_o, 16'h0005);
        step(16'h0004);
        step(16'h0005);
        check("R5 old value matches", lvl_o, 0);
        ctl_w(5'b0_1011, 1'b1);               // buffered, set action
        step(16'h0010);
        check("R5 new value not yet active", lvl_o, 0);
        step(16'hFFFF);
        check("R5 reload at top", val_rdata_o, 16'h0010);
        step(16'h000F);
        step(16'h0010);
        check("R5 new value matches", lvl_o, 1);
    endtask

    task automatic t_release();
        ctl_w(5'b0_0100, 1'b1);               // released, preset low
        tick();
        check("R2 preset low", lvl_o, 0);
        check("R2 oe", pin_oe_o, 1);
        alt_i = 1'b1; #1;
        check("R2 pin alt high", pin_o, 1);
        alt_i = 1'b0; #1;
        check("R2 pin alt low", pin_o, 0);
        ctl_w(5'b0_1000, 1'b1);               // mode-B set but still released
        tick();
        check("R2 preset high", lvl_o, 1);
        alt_i = 1'b1; #1;
        check("R2 released with mode-B", pin_o, 1);
    endtask

    initial begin
        t_reset();
        t_capture();
        t_compare();
        t_buffered();
        t_release();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule